// File: doc/BRIEF.md
# Display List Fetch Sequencer

This block steers one raster graphics plane by walking a byte-coded program held in memory. The program is a stream of one-byte opcodes, some followed by operand bytes. Each opcode either produces picture lines or changes state between them. A line-producing opcode is either a run of blank lines or a mode row of a chosen pixel format. The state-changing opcodes jump within the list, reload the four scan pointers (pixel data, foreground colour, background colour, glyph base), or send a value to an external plane register. The pixel pipeline downstream reads the pointers, the row mode and its modifier bits, and the pixel-row counter. It uses the interrupt pulse to let software run code at chosen lines.

On each line start the sequencer either continues the line-producing instruction in progress, or fetches opcodes until it reaches the next one. It reads through a simple synchronous port that returns data one clock after the request. A jump with its wait bit set stops the walk until vertical blank, which is how a list loops once per frame. Stride and row height come in as inputs from the plane's register file.

Top module: `dl_fetch_seq`

## Requirements
- R1: After reset all four scan pointers and the row counter are zero, row_active and blank_line are low, no read is requested, and dli_pulse and reg_we are low.
- R2: The first read after reset is at address LIST_START. The list is read one byte per request, with each byte taken one clock after rd_en, and the addresses rise by one except after a jump.
- R3: An opcode with bit 3 set starts a mode row. row_mode takes bits 2..0, row_double takes bit 4 and row_multi takes bit 5, and row_active goes high. The row lasts row_height+1 line starts, and row_line counts 0 up to row_height.
- R4: At the line start that ends a mode row, mem_scan grows by stride (modulo 2^PTR_W). The blank lines, the hold state and the control opcodes leave it unchanged.
- R5: An opcode with bit 3 clear and code 0 in bits 2..0 gives N+1 blank lines, where N is bits 6..4. During them blank_line is high, row_active is low, row_mode, row_double and row_multi are zero, and row_line counts from 0.
- R6: If bit 7 is set in a blank-line or mode-row opcode, dli_pulse is high for exactly one clock on that instruction's first line. Otherwise it stays low.
- R7: Code 2 is a jump. The next two bytes, low byte first, become the list address. With bit 7 clear, fetching goes on at once from that address within the same line.
- R8: A jump with bit 7 set makes the output blank (blank_line high, row_active low, row_line zero) and ignores every line start until vblank is seen high. The walk then resumes at the jump target on the next line start.
- R9: Code 3 loads pointers. Bits 4, 5, 6 and 7 flag mem_scan, fg_scan, bg_scan and chr_base, and the flagged pointers each take a 16-bit operand, low byte first, in that order. Pointers that are not flagged keep their values.
- R10: Codes 4 and 5 are register loads, with one operand byte for code 4 and two (low byte first) for code 5. Each gives a single one-clock reg_we. reg_idx is bits 6..4, reg_wide is 1 for code 5, and reg_data is the operand, zero-extended for code 4.
- R11: Codes 1, 6 and 7 are one-byte no-ops. The next byte is decoded as an opcode, and no pointer, output or register write changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-clock pulse at the start of each raster line |
| vblank | input | 1 | High during vertical blank |
| stride | input | STRIDE_W | Bytes added to mem_scan after each mode row |
| row_height | input | CNT_W | Raster lines per mode row, minus one |
| rd_en | output | 1 | Read request to list memory |
| rd_addr | output | PTR_W | Read address |
| rd_data | input | 8 | Read data, valid the clock after rd_en |
| mem_scan | output | PTR_W | Pixel data scan pointer |
| fg_scan | output | PTR_W | Foreground colour scan pointer |
| bg_scan | output | PTR_W | Background colour scan pointer |
| chr_base | output | PTR_W | Glyph generator base pointer |
| row_active | output | 1 | A mode row is being shown |
| blank_line | output | 1 | A blank line is being shown, or the walk is held |
| row_mode | output | 3 | Pixel format of the current row |
| row_double | output | 1 | Double-width pixels |
| row_multi | output | 1 | Multicolour pixels |
| row_line | output | CNT_W | Raster line within the current instruction |
| dli_pulse | output | 1 | Display-list interrupt pulse |
| reg_we | output | 1 | Plane register write strobe |
| reg_idx | output | 3 | Plane register index |
| reg_wide | output | 1 | Write is 16 bits wide |
| reg_data | output | 16 | Plane register write value |

## Verification
The properties assume that line_start comes only while the sequencer is waiting for a line or is held, never while it is still fetching. They also assume that memory answers every request exactly one clock later. The stimulus holds to this by spacing line starts sixty clocks apart, which is longer than the longest fetch burst in the test list, and by serving reads from a registered array. vblank is pulsed only between line starts and lasts several clocks, so the held state always sees it.

// File: rtl/dl_seq_pkg.sv
package dl_seq_pkg;

   localparam int NUM_PTRS = 4;

   typedef enum logic [2:0] {
      C_EMPTY   = 3'd0,
      C_RSV1    = 3'd1,
      C_JUMP    = 3'd2,
      C_LOADMEM = 3'd3,
      C_REG8    = 3'd4,
      C_REG16   = 3'd5,
      C_RSV6    = 3'd6,
      C_RSV7    = 3'd7
   } ctrl_e;

   typedef enum logic [1:0] {
      S_WAIT_LINE,
      S_ISSUE,
      S_RECV,
      S_HOLD
   } st_e;

   typedef struct packed {
      logic       is_row;
      ctrl_e      ctrl;
      logic [2:0] arg;
      logic       flag7;
      logic       dbl;
      logic       multi;
      logic [2:0] mode;
      logic [3:0] mask;
   } op_dec_t;

endpackage

// File: rtl/dl_op_decode.sv
module dl_op_decode
   import dl_seq_pkg::*;
(
   input  logic [7:0] opc,
   output op_dec_t    dec
);

   always_comb begin
      dec.is_row = opc[3];
      dec.ctrl   = ctrl_e'(opc[2:0]);
      dec.mode   = opc[2:0];
      dec.arg    = opc[6:4];
      dec.mask   = opc[7:4];
      dec.flag7  = opc[7];
      dec.dbl    = opc[4];
      dec.multi  = opc[5];
   end

endmodule

// File: rtl/dl_line_timer.sv
module dl_line_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             clear,
   output logic             done,
   output logic [CNT_W-1:0] line_cnt
);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain   <= '0;
         line_cnt <= '0;
      end else if (clear) begin
         remain   <= '0;
         line_cnt <= '0;
      end else if (load) begin
         remain   <= load_val;
         line_cnt <= '0;
      end else if (tick && remain != '0) begin
         remain   <= remain - 1'b1;
         line_cnt <= line_cnt + 1'b1;
      end
   end

   assign done = (remain == '0);

endmodule

// File: rtl/dl_scan_bank.sv
module dl_scan_bank #(
   parameter int PTR_W    = 16,
   parameter int STRIDE_W = 8,
   parameter int NUM      = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic [NUM-1:0]            load_sel,
   input  logic [15:0]               load_val,
   input  logic                      adv_en,
   input  logic [STRIDE_W-1:0]       adv_amt,
   output logic [NUM-1:0][PTR_W-1:0] ptrs
);

   for (genvar g = 0; g < NUM; g++) begin : g_ptr
      if (g == 0) begin : g_adv
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptrs[g] <= '0;
            else if (load_en && load_sel[g])
               ptrs[g] <= PTR_W'(load_val);
            else if (adv_en)
               ptrs[g] <= ptrs[g] + PTR_W'(adv_amt);
         end
      end else begin : g_fixed
         always_ff @(posedge clk) begin
            if (!rst_n)
               ptrs[g] <= '0;
            else if (load_en && load_sel[g])
               ptrs[g] <= PTR_W'(load_val);
         end
      end
   end

endmodule

// File: rtl/dl_fetch_seq.sv
module dl_fetch_seq
   import dl_seq_pkg::*;
#(
   parameter int               PTR_W      = 16,
   parameter int               CNT_W      = 8,
   parameter int               STRIDE_W   = 8,
   parameter logic [PTR_W-1:0] LIST_START = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_start,
   input  logic                vblank,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [CNT_W-1:0]    row_height,
   output logic                rd_en,
   output logic [PTR_W-1:0]    rd_addr,
   input  logic [7:0]          rd_data,
   output logic [PTR_W-1:0]    mem_scan,
   output logic [PTR_W-1:0]    fg_scan,
   output logic [PTR_W-1:0]    bg_scan,
   output logic [PTR_W-1:0]    chr_base,
   output logic                row_active,
   output logic                blank_line,
   output logic [2:0]          row_mode,
   output logic                row_double,
   output logic                row_multi,
   output logic [CNT_W-1:0]    row_line,
   output logic                dli_pulse,
   output logic                reg_we,
   output logic [2:0]          reg_idx,
   output logic                reg_wide,
   output logic [15:0]         reg_data
);

   if (PTR_W < 16) begin : g_bad_ptr
      $error("PTR_W must hold a 16-bit operand");
   end
   if (CNT_W < 3) begin : g_bad_cnt
      $error("CNT_W must hold a blank-line count");
   end
   if (STRIDE_W > PTR_W) begin : g_bad_stride
      $error("STRIDE_W must not exceed PTR_W");
   end

   st_e              st;
   logic [PTR_W-1:0] list_ptr;
   ctrl_e            op_ctrl_q;
   logic [2:0]       op_arg_q;
   logic             op_f7_q;
   logic             in_opnd;
   logic             byte_hi;
   logic [7:0]       lo_q;
   logic [3:0]       mask_q;
   logic             cur_row;
   op_dec_t          dec;

   dl_op_decode u_dec (.opc(rd_data), .dec(dec));

   logic             recv_op, recv_arg, arg_done;
   logic [15:0]      arg_word;
   logic [3:0]       first_sel, mask_left;
   logic             line_tick, tmr_done, tmr_load, hold_enter;
   logic             scan_load, scan_adv;
   logic [CNT_W-1:0] tmr_val;

   assign recv_op    = (st == S_RECV) && !in_opnd;
   assign recv_arg   = (st == S_RECV) && in_opnd;
   assign arg_done   = recv_arg && (byte_hi || op_ctrl_q == C_REG8);
   assign arg_word   = (op_ctrl_q == C_REG8) ? {8'h00, rd_data} : {rd_data, lo_q};
   assign first_sel  = mask_q & (~mask_q + 4'd1);
   assign mask_left  = mask_q & ~first_sel;
   assign line_tick  = (st == S_WAIT_LINE) && line_start;
   assign tmr_load   = recv_op && (dec.is_row || dec.ctrl == C_EMPTY);
   assign tmr_val    = dec.is_row ? row_height : CNT_W'(dec.arg);
   assign hold_enter = arg_done && op_ctrl_q == C_JUMP && op_f7_q;
   assign scan_load  = arg_done && op_ctrl_q == C_LOADMEM;
   assign scan_adv   = line_tick && tmr_done && cur_row;

   dl_line_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .tick(line_tick), .clear(hold_enter), .done(tmr_done), .line_cnt(row_line)
   );

   logic [NUM_PTRS-1:0][PTR_W-1:0] scan;

   dl_scan_bank #(.PTR_W(PTR_W), .STRIDE_W(STRIDE_W), .NUM(NUM_PTRS)) u_scan (
      .clk(clk), .rst_n(rst_n), .load_en(scan_load), .load_sel(first_sel),
      .load_val(arg_word), .adv_en(scan_adv), .adv_amt(stride), .ptrs(scan)
   );

   assign mem_scan = scan[0];
   assign fg_scan  = scan[1];
   assign bg_scan  = scan[2];
   assign chr_base = scan[3];
   assign rd_en    = (st == S_ISSUE);
   assign rd_addr  = list_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= S_WAIT_LINE;
         list_ptr   <= LIST_START;
         op_ctrl_q  <= C_EMPTY;
         op_arg_q   <= '0;
         op_f7_q    <= 1'b0;
         in_opnd    <= 1'b0;
         byte_hi    <= 1'b0;
         lo_q       <= '0;
         mask_q     <= '0;
         cur_row    <= 1'b0;
         row_active <= 1'b0;
         blank_line <= 1'b0;
         row_mode   <= '0;
         row_double <= 1'b0;
         row_multi  <= 1'b0;
         dli_pulse  <= 1'b0;
         reg_we     <= 1'b0;
         reg_idx    <= '0;
         reg_wide   <= 1'b0;
         reg_data   <= '0;
      end else begin
         dli_pulse <= 1'b0;
         reg_we    <= 1'b0;
         case (st)
            S_WAIT_LINE: begin
               if (line_start && tmr_done) st <= S_ISSUE;
            end
            S_ISSUE: begin
               list_ptr <= list_ptr + 1'b1;
               st       <= S_RECV;
            end
            S_RECV: begin
               if (!in_opnd) begin
                  op_ctrl_q <= dec.ctrl;
                  op_arg_q  <= dec.arg;
                  op_f7_q   <= dec.flag7;
                  byte_hi   <= 1'b0;
                  if (dec.is_row) begin
                     row_active <= 1'b1;
                     blank_line <= 1'b0;
                     row_mode   <= dec.mode;
                     row_double <= dec.dbl;
                     row_multi  <= dec.multi;
                     cur_row    <= 1'b1;
                     dli_pulse  <= dec.flag7;
                     st         <= S_WAIT_LINE;
                  end else begin
                     case (dec.ctrl)
                        C_EMPTY: begin
                           row_active <= 1'b0;
                           blank_line <= 1'b1;
                           row_mode   <= '0;
                           row_double <= 1'b0;
                           row_multi  <= 1'b0;
                           cur_row    <= 1'b0;
                           dli_pulse  <= dec.flag7;
                           st         <= S_WAIT_LINE;
                        end
                        C_JUMP, C_REG8, C_REG16: begin
                           in_opnd <= 1'b1;
                           st      <= S_ISSUE;
                        end
                        C_LOADMEM: begin
                           mask_q  <= dec.mask;
                           in_opnd <= (dec.mask != 4'd0);
                           st      <= S_ISSUE;
                        end
                        default: st <= S_ISSUE;
                     endcase
                  end
               end else if (!arg_done) begin
                  lo_q    <= rd_data;
                  byte_hi <= 1'b1;
                  st      <= S_ISSUE;
               end else begin
                  byte_hi <= 1'b0;
                  case (op_ctrl_q)
                     C_JUMP: begin
                        list_ptr <= PTR_W'(arg_word);
                        in_opnd  <= 1'b0;
                        if (op_f7_q) begin
                           row_active <= 1'b0;
                           blank_line <= 1'b1;
                           row_mode   <= '0;
                           row_double <= 1'b0;
                           row_multi  <= 1'b0;
                           cur_row    <= 1'b0;
                           st         <= S_HOLD;
                        end else begin
                           st <= S_ISSUE;
                        end
                     end
                     C_LOADMEM: begin
                        mask_q  <= mask_left;
                        in_opnd <= (mask_left != 4'd0);
                        st      <= S_ISSUE;
                     end
                     default: begin
                        reg_we   <= 1'b1;
                        reg_idx  <= op_arg_q;
                        reg_wide <= (op_ctrl_q == C_REG16);
                        reg_data <= arg_word;
                        in_opnd  <= 1'b0;
                        st       <= S_ISSUE;
                     end
                  endcase
               end
            end
            S_HOLD: begin
               if (vblank) st <= S_WAIT_LINE;
            end
            default: st <= S_WAIT_LINE;
         endcase
      end
   end

endmodule

// File: rtl/dl_fetch_seq_chk.sv
module dl_fetch_seq_chk #(
   parameter int PTR_W = 16,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_start,
   input logic             rd_en,
   input logic [PTR_W-1:0] mem_scan,
   input logic             row_active,
   input logic             blank_line,
   input logic [CNT_W-1:0] row_line,
   input logic             dli_pulse,
   input logic             reg_we
);

   // R2
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   // R6
   dli_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dli_pulse |=> !dli_pulse);

   // R6
   dli_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dli_pulse |-> (row_active || blank_line));

   // R10
   reg_we_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R3
   row_line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_line) |-> ($past(line_start) || row_line == '0));

   // R5
   row_blank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(row_active && blank_line));

   // R4
   scan_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_scan) |-> ($past(line_start) || $past(rd_en, 2)));

endmodule

bind dl_fetch_seq dl_fetch_seq_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dl_fetch_seq_bench.sv
`timescale 1ns/1ps
module dl_fetch_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        line_start, vblank;
   logic [7:0]  stride, row_height;
   logic        rd_en;
   logic [15:0] rd_addr;
   logic [7:0]  rd_data;
   logic [15:0] mem_scan, fg_scan, bg_scan, chr_base;
   logic        row_active, blank_line, row_double, row_multi;
   logic [2:0]  row_mode;
   logic [7:0]  row_line;
   logic        dli_pulse, reg_we, reg_wide;
   logic [2:0]  reg_idx;
   logic [15:0] reg_data;

   always #2.5 clk = ~clk;

   dl_fetch_seq u_dl_fetch_seq (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .vblank(vblank),
      .stride(stride), .row_height(row_height), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .mem_scan(mem_scan), .fg_scan(fg_scan), .bg_scan(bg_scan),
      .chr_base(chr_base), .row_active(row_active), .blank_line(blank_line),
      .row_mode(row_mode), .row_double(row_double), .row_multi(row_multi),
      .row_line(row_line), .dli_pulse(dli_pulse), .reg_we(reg_we),
      .reg_idx(reg_idx), .reg_wide(reg_wide), .reg_data(reg_data)
   );

   logic [7:0] mem [256];
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[7:0]];

   int dli_total = 0;
   int reg_cnt = 0;
   logic [2:0]  w_idx  [4];
   logic        w_wide [4];
   logic [15:0] w_data [4];
   logic        seen_rd = 1'b0;
   logic [15:0] first_addr = '0;

   always @(posedge clk) begin
      if (dli_pulse) dli_total <= dli_total + 1;
      if (reg_we && reg_cnt < 4) begin
         w_idx[reg_cnt]  <= reg_idx;
         w_wide[reg_cnt] <= reg_wide;
         w_data[reg_cnt] <= reg_data;
      end
      if (reg_we) reg_cnt <= reg_cnt + 1;
      if (rd_en && !seen_rd) begin
         seen_rd    <= 1'b1;
         first_addr <= rd_addr;
      end
   end

   int checks = 0;
   int errors = 0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
      end
   endtask

   typedef struct packed {
      logic        vb;
      logic        act;
      logic        blk;
      logic [2:0]  mode;
      logic        dbl;
      logic        mul;
      logic [7:0]  line;
      logic [15:0] ms;
      logic        dli;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 8'd0, 16'h2000, 1'b0},
      '{1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 1'b1, 8'd1, 16'h2000, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h2030, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd1, 16'h2030, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd2, 16'h2030, 1'b0},
      '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'd0, 16'h2030, 1'b1},
      '{1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 8'd1, 16'h2030, 1'b0},
      '{1'b0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 8'd0, 16'h3000, 1'b0},
      '{1'b0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0, 8'd1, 16'h3000, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h3030, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h3030, 1'b0},
      '{1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h3030, 1'b1},
      '{1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 8'd0, 16'h3030, 1'b0},
      '{1'b0, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0, 8'd1, 16'h3030, 1'b0},
      '{1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h3060, 1'b0},
      '{1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 8'd0, 16'h3060, 1'b1}
   };

   task automatic poke(input int a, input logic [7:0] v);
      mem[a] = v;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int a = 0; a < 256; a++) mem[a] = 8'h00;
      poke(0, 8'h13); poke(1, 8'h00); poke(2, 8'h20);
      poke(3, 8'h39); poke(4, 8'h20); poke(5, 8'h86); poke(6, 8'h88);
      poke(7, 8'h44); poke(8, 8'h5A);
      poke(9, 8'h75); poke(10, 8'h34); poke(11, 8'h12);
      poke(12, 8'hF3);
      poke(13, 8'h00); poke(14, 8'h30); poke(15, 8'h11); poke(16, 8'h40);
      poke(17, 8'h22); poke(18, 8'h50); poke(19, 8'h33); poke(20, 8'h60);
      poke(21, 8'h0E); poke(22, 8'h82); poke(23, 8'h40); poke(24, 8'h00);
      poke(8'h40, 8'h80); poke(8'h41, 8'h02); poke(8'h42, 8'h50); poke(8'h43, 8'h00);
      poke(8'h50, 8'h0B); poke(8'h51, 8'h82); poke(8'h52, 8'h40); poke(8'h53, 8'h00);

      rst_n = 1'b0; line_start = 1'b0; vblank = 1'b0;
      stride = 8'h30; row_height = 8'd1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check("R1", "mem_scan", mem_scan, 0);
      check("R1", "fg_scan", fg_scan, 0);
      check("R1", "bg_scan", bg_scan, 0);
      check("R1", "chr_base", chr_base, 0);
      check("R1", "row_active", row_active, 0);
      check("R1", "blank_line", blank_line, 0);
      check("R1", "row_line", row_line, 0);
      check("R1", "rd_en", rd_en, 0);
      check("R1", "dli_pulse", dli_pulse, 0);
      check("R1", "reg_we", reg_we, 0);

      for (int i = 0; i < NV; i++) begin
         int d0;
         if (TBL[i].vb) begin
            vblank = 1'b1;
            repeat (3) @(negedge clk);
            vblank = 1'b0;
            repeat (2) @(negedge clk);
         end
         d0 = dli_total;
         line_start = 1'b1;
         @(negedge clk);
         line_start = 1'b0;
         repeat (60) @(negedge clk);
         check("R3", $sformatf("line %0d row_active", i), row_active, TBL[i].act);
         check("R5", $sformatf("line %0d blank_line", i), blank_line, TBL[i].blk);
         check("R3", $sformatf("line %0d row_mode", i), row_mode, TBL[i].mode);
         check("R3", $sformatf("line %0d row_double", i), row_double, TBL[i].dbl);
         check("R3", $sformatf("line %0d row_multi", i), row_multi, TBL[i].mul);
         check("R3", $sformatf("line %0d row_line", i), row_line, TBL[i].line);
         check("R4", $sformatf("line %0d mem_scan", i), mem_scan, TBL[i].ms);
         check("R6", $sformatf("line %0d dli cycles", i), dli_total - d0, TBL[i].dli);
         if (i == 0) begin
            // R9 unflagged pointers untouched by the first pointer load
            check("R9", "fg_scan after mem-only load", fg_scan, 0);
            check("R9", "chr_base after mem-only load", chr_base, 0);
         end
         if (i == 5) check("R11", "mode row after reserved op", row_active, 1);
         if (i == 10) begin
            // R8 line start ignored while held
            check("R8", "held blank", blank_line, 1);
            check("R8", "held mem_scan", mem_scan, 16'h3030);
         end
         if (i == 12) check("R7", "jump target mode", row_mode, 3);
      end

      check("R9", "fg_scan", fg_scan, 16'h4011);
      check("R9", "bg_scan", bg_scan, 16'h5022);
      check("R9", "chr_base", chr_base, 16'h6033);
      check("R10", "write count", reg_cnt, 2);
      check("R10", "w0 idx", w_idx[0], 4);
      check("R10", "w0 wide", w_wide[0], 0);
      check("R10", "w0 data", w_data[0], 16'h005A);
      check("R10", "w1 idx", w_idx[1], 7);
      check("R10", "w1 wide", w_wide[1], 1);
      check("R10", "w1 data", w_data[1], 16'h1234);
      check("R2", "first read address", first_addr, 0);
      finish_run();
   end

endmodule